// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small processor core and decides which one the core should service next. It takes three active-low external request pins, seven internal peripheral request pulses (host-port write and read, two serial ports with transmit and receive each, and a timer) and a non-maskable restart request. Each external pin can be configured to capture a falling edge or to follow its level. Every source except restart passes through an enable mask, and the highest-priority surviving request is offered to the core.

The core accepts the offered request by pulsing `enter`. One cycle later the controller returns a single-cycle `ack` strobe together with the vector address of the accepted source. Vector slots lie four instruction words apart. When the core finishes a service routine it pulses `leave`. The controller keeps a record of the services currently in progress. A control bit selects the mode: in nested mode a strictly higher-priority request may preempt a running service; in sequential mode nothing is offered until the running service has ended. A second control bit lets two external pins take over the request slots of the second serial port.

Top module: `ivc_vec_ctrl`

## Requirements
- R1: The restart request `rst_req` (slot 0) cannot be masked, has the highest priority, and is offered whenever it is high, whatever services are active and whichever mode is selected. Its acknowledge (vector `VEC_BASE`) empties the record of active services and discards every latched request.
- R2: When `ctrl[k]` is 1 (k = 0..2), pin `ext_irq_n[k]` is edge-sensitive. A high-to-low transition is captured, stays pending after the pin returns high, and is cleared when that slot is acknowledged.
- R3: When `ctrl[k]` is 0, pin `ext_irq_n[k]` is level-sensitive. It requests while the pin is low and stops requesting as soon as the pin is high. Nothing is latched.
- R4: Priority follows slot index, with 0 the highest: 0 restart, 1 `ext_irq_n[2]`, 2 host write, 3 host read, 4 serial-0 transmit, 5 serial-0 receive, 6 serial-1 transmit or `ext_irq_n[1]`, 7 serial-1 receive or `ext_irq_n[0]`, 8 timer.
- R5: `irq_en[k]` set to 1 enables slot k+1. A request whose slot is disabled is not offered but stays pending, and it is offered once the slot is enabled again.
- R6: When `enter` is high in a cycle in which `int_req` is high, the next cycle shows `ack` high for exactly one cycle and `vec` = `VEC_BASE` + 4 × slot. `vec` holds that value until the next acknowledge.
- R7: With `ctrl[4]` = 1 (nested mode), a request is offered while services are active only if its slot number is lower than that of every active service.
- R8: With `ctrl[4]` = 0 (sequential mode), no request other than restart is offered while any service is active.
- R9: A `leave` pulse ends the most recently entered service, which is the highest-priority active one. Lower-priority active services remain recorded.
- R10: With `ctrl[3]` = 1, slots 6 and 7 take their requests from `ext_irq_n[1]` and `ext_irq_n[0]`, and serial-1 pulses stay pending but are not offered. With `ctrl[3]` = 0, those two slots take serial-1 requests and those two pins are ignored.
- R11: A one-cycle pulse on `per_req` is captured and stays pending until its slot is acknowledged. The bits map as follows: 0 host write, 1 host read, 2 serial-0 transmit, 3 serial-0 receive, 4 serial-1 transmit, 5 serial-1 receive, 6 timer.
- R12: After `rst`, nothing is pending, no service is active, `int_req` and `ack` are 0 and `vec` equals `VEC_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 3 | Active-low external request pins |
| per_req | input | 7 | Internal peripheral request pulses |
| rst_req | input | 1 | Non-maskable restart request |
| irq_en | input | 8 | Enable mask, bit k enables slot k+1 |
| ctrl | input | 5 | [2:0] edge select per pin, [3] serial-1 pins take over, [4] nested mode |
| enter | input | 1 | Core accepts the offered request |
| leave | input | 1 | Core returns from the current service |
| int_req | output | 1 | An eligible request is offered |
| ack | output | 1 | Single-cycle acknowledge strobe |
| vec | output | ADDR_W | Vector address of the last acknowledged source |

## Verification
The bench aims at the cases where a plausible design goes wrong. It lets an edge-captured pin return high before the core accepts the request; a controller that did not latch the edge would drop that request. It holds a disabled pulse request and enables it later; a controller that discarded masked requests would never offer it. In nested mode it offers a request that sits in priority between two active services, both before and after a `leave`; a controller with a wrong compare or a wrong pop order would offer it while the higher service still runs, or miss it afterwards. It also sends restart while all slots are disabled and a service is active, then checks that the alternate pin routing hides the serial-1 pulse and later reveals it.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int NSRC  = 9;
    localparam int IDX_W = $clog2(NSRC);
    localparam int NEXT  = 3;
    localparam int NPER  = 7;

    typedef logic [IDX_W-1:0] slot_t;

    typedef enum slot_t {
        SL_RESET   = 4'd0,
        SL_EXT2    = 4'd1,
        SL_HOST_WR = 4'd2,
        SL_HOST_RD = 4'd3,
        SL_SP0_TX  = 4'd4,
        SL_SP0_RX  = 4'd5,
        SL_SP1_TX  = 4'd6,
        SL_SP1_RX  = 4'd7,
        SL_TIMER   = 4'd8
    } slot_e;

    typedef struct packed {
        logic            nest;
        logic            alt_sp1;
        logic [NEXT-1:0] edge_mode;
    } ctrl_t;

    typedef struct packed {
        logic  hit;
        slot_t idx;
    } pick_t;

    // lowest set index wins (index 0 is the highest priority)
    function automatic pick_t first_set(input logic [NSRC-1:0] v);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = slot_t'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [NSRC-1:0] slot_onehot(input slot_t i);
        return NSRC'(1) << i;
    endfunction
endpackage

// File: rtl/ivc_ext_front.sv
module ivc_ext_front #(
    parameter int NPIN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_n,
    input  logic [NPIN-1:0] edge_mode,
    input  logic [NPIN-1:0] clr,
    output logic [NPIN-1:0] req
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic prev_n;
        logic held;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_n <= 1'b1;
                held   <= 1'b0;
            end else begin
                prev_n <= pin_n[g];
                if (edge_mode[g] && prev_n && !pin_n[g])
                    held <= 1'b1;
                else if (clr[g])
                    held <= 1'b0;
            end
        end

        assign req[g] = edge_mode[g] ? held : ~pin_n[g];
    end
endmodule

// File: rtl/ivc_pulse_latch.sv
module ivc_pulse_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set;
    end
endmodule

// File: rtl/ivc_active.sv
module ivc_active
    import ivc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] push,
    input  logic            flush,
    input  logic            pop,
    output logic            act_any,
    output slot_t           act_top
);
    logic [NSRC-1:0] act;
    logic [NSRC-1:0] after_pop;
    pick_t           top;

    // removing the lowest set bit ends the highest-priority service
    always_comb after_pop = pop ? (act & (act - NSRC'(1))) : act;

    always_ff @(posedge clk) begin
        if (rst || flush) act <= '0;
        else              act <= after_pop | push;
    end

    always_comb top = first_set(act);
    assign act_any = top.hit;
    assign act_top = top.idx;
endmodule

// File: rtl/ivc_vec_ctrl.sv
module ivc_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int VEC_BASE = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NEXT-1:0]      ext_irq_n,
    input  logic [NPER-1:0]      per_req,
    input  logic                 rst_req,
    input  logic [NSRC-2:0]      irq_en,
    input  logic [4:0]           ctrl,
    input  logic                 enter,
    input  logic                 leave,
    output logic                 int_req,
    output logic                 ack,
    output logic [ADDR_W-1:0]    vec
);
    ctrl_t           cfg;
    logic [NEXT-1:0] ext_req, ext_clr;
    logic [NPER-1:0] per_pend, per_clr;
    logic [NSRC-1:0] slot_req, slot_live, ack_oh;
    pick_t           win;
    logic            act_any;
    slot_t           act_top;
    logic            fire, rst_ack;

    assign cfg = ctrl_t'(ctrl);

    ivc_ext_front #(.NPIN(NEXT)) u_ext (
        .clk(clk), .rst(rst), .pin_n(ext_irq_n), .edge_mode(cfg.edge_mode),
        .clr(ext_clr), .req(ext_req)
    );

    ivc_pulse_latch #(.N(NPER)) u_per (
        .clk(clk), .rst(rst), .set(per_req), .clr(per_clr), .pend(per_pend)
    );

    always_comb begin
        slot_req             = '0;
        slot_req[SL_RESET]   = rst_req;
        slot_req[SL_EXT2]    = ext_req[2];
        slot_req[SL_HOST_WR] = per_pend[0];
        slot_req[SL_HOST_RD] = per_pend[1];
        slot_req[SL_SP0_TX]  = per_pend[2];
        slot_req[SL_SP0_RX]  = per_pend[3];
        slot_req[SL_SP1_TX]  = cfg.alt_sp1 ? ext_req[1] : per_pend[4];
        slot_req[SL_SP1_RX]  = cfg.alt_sp1 ? ext_req[0] : per_pend[5];
        slot_req[SL_TIMER]   = per_pend[6];
    end

    assign slot_live = slot_req & {irq_en, 1'b1};
    always_comb win = first_set(slot_live);

    ivc_active u_act (
        .clk(clk), .rst(rst), .push(rst_ack ? '0 : ack_oh), .flush(rst_ack),
        .pop(leave), .act_any(act_any), .act_top(act_top)
    );

    assign int_req = win.hit && ((win.idx == SL_RESET) || !act_any ||
                                 (cfg.nest && (win.idx < act_top)));
    assign fire    = enter && int_req;
    assign ack_oh  = fire ? slot_onehot(win.idx) : '0;
    assign rst_ack = fire && (win.idx == SL_RESET);

    always_comb begin
        ext_clr[2] = ack_oh[SL_EXT2] | rst_ack;
        ext_clr[1] = (ack_oh[SL_SP1_TX] & cfg.alt_sp1) | rst_ack;
        ext_clr[0] = (ack_oh[SL_SP1_RX] & cfg.alt_sp1) | rst_ack;
        per_clr[0] = ack_oh[SL_HOST_WR] | rst_ack;
        per_clr[1] = ack_oh[SL_HOST_RD] | rst_ack;
        per_clr[2] = ack_oh[SL_SP0_TX]  | rst_ack;
        per_clr[3] = ack_oh[SL_SP0_RX]  | rst_ack;
        per_clr[4] = (ack_oh[SL_SP1_TX] & ~cfg.alt_sp1) | rst_ack;
        per_clr[5] = (ack_oh[SL_SP1_RX] & ~cfg.alt_sp1) | rst_ack;
        per_clr[6] = ack_oh[SL_TIMER]   | rst_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            vec <= ADDR_W'(VEC_BASE);
        end else begin
            ack <= fire;
            if (fire) vec <= ADDR_W'(VEC_BASE) + (ADDR_W'(win.idx) << 2);
        end
    end
endmodule

// File: rtl/ivc_vec_ctrl_chk.sv
module ivc_vec_ctrl_chk #(
    parameter int ADDR_W   = 14,
    parameter int VEC_BASE = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              pin2_n,
    input logic              rst_req,
    input logic              en_ext2,
    input logic              edge2,
    input logic              nest,
    input logic              enter,
    input logic              leave,
    input logic              int_req,
    input logic              ack,
    input logic [ADDR_W-1:0] vec
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] TOP  = ADDR_W'(VEC_BASE + 32);

    logic [4:0] depth;

    always_ff @(posedge clk) begin
        if (rst) depth <= '0;
        else if (ack && vec == BASE) depth <= '0;
        else depth <= depth + 5'(ack) - 5'(leave && depth != 0);
    end

    AST_RST_UNMASKABLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> int_req);                                            // R1
    AST_ACK_AFTER_ENTER: assert property (@(posedge clk) disable iff (rst)
        ack |-> ($past(enter) && $past(int_req)));                       // R6
    AST_VEC_SPACING: assert property (@(posedge clk) disable iff (rst)
        ack |-> (vec[1:0] == BASE[1:0]));                                // R6
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        ack |-> (vec >= BASE && vec <= TOP));                            // R4
    AST_SEQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (!nest && depth != 0 && !ack && !rst_req) |-> !int_req);         // R8
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!edge2 && !pin2_n && en_ext2 && depth == 0 && !ack) |-> int_req); // R3
endmodule

bind ivc_vec_ctrl ivc_vec_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst(rst), .pin2_n(ext_irq_n[2]), .rst_req(rst_req),
    .en_ext2(irq_en[0]), .edge2(ctrl[2]), .nest(ctrl[4]), .enter(enter),
    .leave(leave), .int_req(int_req), .ack(ack), .vec(vec)
);

// File: tb/ivc_vec_ctrl_bench.sv
module ivc_vec_ctrl_bench;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    ext_irq_n = 3'b111;
    logic [6:0]    per_req = '0;
    logic          rst_req = 1'b0;
    logic [7:0]    irq_en = 8'hFF;
    logic [4:0]    ctrl = '0;
    logic          enter = 1'b0;
    logic          leave = 1'b0;
    logic          int_req, ack;
    logic [AW-1:0] vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ivc_vec_ctrl #(.ADDR_W(AW), .VEC_BASE(0)) u_ivc_vec_ctrl (
        .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .per_req(per_req),
        .rst_req(rst_req), .irq_en(irq_en), .ctrl(ctrl), .enter(enter),
        .leave(leave), .int_req(int_req), .ack(ack), .vec(vec)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic pulse_per(input logic [6:0] m);
        per_req = m;
        @(negedge clk);
        per_req = '0;
        #1;
    endtask

    task automatic take(input string tag, input int exp_vec);
        enter = 1'b1;
        @(negedge clk);
        enter = 1'b0;
        chk({tag, " ack"}, 32'(ack), 1);
        chk({tag, " vec"}, 32'(vec), exp_vec);
        @(negedge clk);
        chk({tag, " ack single cycle R6"}, 32'(ack), 0);
    endtask

    task automatic ret();
        leave = 1'b1;
        @(negedge clk);
        leave = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        chk("R12 int_req", 32'(int_req), 0);
        chk("R12 ack", 32'(ack), 0);
        chk("R12 vec", 32'(vec), 0);
    endtask

    task automatic t_priority();
        pulse_per(7'b1000010);                    // R11 timer + host read
        chk("R11 captured", 32'(int_req), 1);
        take("R4 host read first", 12);
        chk("R8 busy hides timer", 32'(int_req), 0);
        ret();
        chk("R9 leave frees", 32'(int_req), 1);
        take("R4 timer next", 32);
        ret();
    endtask

    task automatic t_mask();
        irq_en = 8'h7F;
        pulse_per(7'b1000000);
        chk("R5 masked timer", 32'(int_req), 0);
        irq_en = 8'hFF;
        #1;
        chk("R5 pending after unmask", 32'(int_req), 1);
        take("R5 timer vec", 32);
        ret();
    endtask

    task automatic t_edge();
        ctrl = 5'b00100;
        ext_irq_n[2] = 1'b0;
        @(negedge clk);
        ext_irq_n[2] = 1'b1;
        @(negedge clk);
        chk("R2 edge held", 32'(int_req), 1);
        take("R2 ext2 vec", 4);
        ret();
        chk("R2 cleared by ack", 32'(int_req), 0);
    endtask

    task automatic t_level();
        ctrl = 5'b00000;
        ext_irq_n[2] = 1'b0;
        #1;
        chk("R3 level low", 32'(int_req), 1);
        take("R3 ext2 vec", 4);
        ret();
        chk("R3 still low", 32'(int_req), 1);
        ext_irq_n[2] = 1'b1;
        #1;
        chk("R3 not latched", 32'(int_req), 0);
        @(negedge clk);
    endtask

    task automatic t_nest();
        ctrl = 5'b10000;
        pulse_per(7'b1000000);
        take("R7 timer", 32);
        pulse_per(7'b0000001);
        chk("R7 preempt offered", 32'(int_req), 1);
        take("R7 host write", 8);
        pulse_per(7'b0000100);
        chk("R7 lower blocked", 32'(int_req), 0);
        ret();
        chk("R9 pops host write", 32'(int_req), 1);
        take("R7 sp0 tx", 16);
        ret();
        ret();
        chk("R9 all ended", 32'(int_req), 0);
    endtask

    task automatic t_seq();
        ctrl = 5'b00000;
        pulse_per(7'b1000000);
        take("R8 timer", 32);
        pulse_per(7'b0000001);
        chk("R8 no preempt", 32'(int_req), 0);
        ret();
        chk("R8 offered after leave", 32'(int_req), 1);
        take("R8 host write", 8);
        ret();
    endtask

    task automatic t_restart();
        ctrl = 5'b00000;
        pulse_per(7'b1000000);
        take("R1 timer", 32);
        pulse_per(7'b0000010);                    // host read, should be discarded
        irq_en = 8'h00;
        rst_req = 1'b1;
        #1;
        chk("R1 unmaskable", 32'(int_req), 1);
        take("R1 restart vec", 0);
        rst_req = 1'b0;
        irq_en = 8'hFF;
        #1;
        chk("R1 latches discarded", 32'(int_req), 0);
        pulse_per(7'b1000000);
        chk("R1 active flushed", 32'(int_req), 1);
        take("R1 timer again", 32);
        ret();
    endtask

    task automatic t_alt();
        ctrl = 5'b01000;
        ext_irq_n[0] = 1'b0;
        #1;
        chk("R10 pin0 on slot 7", 32'(int_req), 1);
        take("R10 slot7 vec", 28);
        ext_irq_n[0] = 1'b1;
        ret();
        chk("R10 pin released", 32'(int_req), 0);
        pulse_per(7'b0100000);
        chk("R10 serial1 hidden", 32'(int_req), 0);
        ctrl = 5'b00000;
        #1;
        chk("R10 serial1 revealed", 32'(int_req), 1);
        take("R10 serial1 rx vec", 28);
        ret();
        ext_irq_n[1] = 1'b0;
        #1;
        chk("R10 pin1 ignored", 32'(int_req), 0);
        ext_irq_n[1] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_priority();
        t_mask();
        t_edge();
        t_level();
        t_nest();
        t_seq();
        t_restart();
        t_alt();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule